// File: doc/BRIEF.md
# SPI Serial Clock Generator

This block derives the serial clock of an SPI master from the system clock. It also produces two single-cycle strobes that tell a neighbouring shift register when to drive the next bit and when to capture the incoming bit. The divide ratio comes from a 5-bit prescale field that has two encodings. When the top bit is clear, the low nibble is the ratio itself. When the top bit is set, the ratio is twice the low nibble, which gives even ratios up to 30. Clock polarity and phase select the usual four SPI modes.

For very fast serial clocks there is a capture-edge option. It delays the capture strobe by half a serial period, so input data returning late from a slow device is still taken correctly. The generator takes a new ratio and mode at the start of each transfer and holds them until the transfer ends. While it is idle, the serial clock rests at the polarity level.

A transfer starts when the enable is high and the stop request is low. A stop request ends the transfer cleanly at the next bit boundary. Dropping the enable ends it at once.

Top module: `spi_sclk_gen`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, `sclk_o`, `launch_o` and `sample_o` are 0.
- R2: The bit period N comes from `presc_i` as follows. If `presc_i[4]`=0, N = `presc_i[3:0]`. If `presc_i[4]`=1, N = 2·`presc_i[3:0]`. Any result below 2 (codes 0, 1 and 16) runs at N=2. Code 31 gives N=30, the largest ratio.
- R3: `launch_o` is high for exactly one cycle at the first cycle of every bit period, so successive launches are N cycles apart.
- R4: Let H = ceil(N/2). In cycles 0..H-1 of a bit period `sclk_o` equals `cpol_i` XOR `cpha_i`. In cycles H..N-1 it is the inverse of that level.
- R5: With `capt_alt_i`=0, `sample_o` is high for one cycle at cycle H of each bit period, the first cycle of the second half.
- R6: With `capt_alt_i`=1, there is no sample strobe in mid-bit. The strobe moves to the bit boundary instead: it coincides with the next launch, or with the return to idle after the last bit.
- R7: While idle, `sclk_o` equals the `cpol_i` value of the previous cycle, and no launch strobe is produced.
- R8: When the block is idle and `run_en_i`=1 and `stop_req_i`=0 at a clock edge, `launch_o` is high in the cycle that follows.
- R9: When `stop_req_i`=1 during a transfer, the current bit period runs to its end. The block then goes idle with `sclk_o` at the latched polarity and no further launch.
- R10: When `run_en_i`=0 during a transfer, the very next cycle is idle: `sclk_o` is at the latched polarity and both strobes are low.
- R11: Changes to `presc_i`, `cpol_i`, `cpha_i` and `capt_alt_i` during a transfer have no effect until the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en_i | input | 1 | Enable; low forces idle at once |
| stop_req_i | input | 1 | Request to stop at the next bit boundary |
| presc_i | input | 5 | Prescale code (bit 4 selects the doubled encoding) |
| cpol_i | input | 1 | Clock polarity (idle level) |
| cpha_i | input | 1 | Clock phase |
| capt_alt_i | input | 1 | Move capture to the alternate edge |
| sclk_o | output | 1 | Serial clock |
| launch_o | output | 1 | One-cycle strobe: drive next bit |
| sample_o | output | 1 | One-cycle strobe: capture input bit |

## Verification
A corrupted position counter or latched ratio shows first as launch strobes spaced by the wrong number of cycles, and this is visible within one bit period. A wrong half-point shows in the same period, as a serial clock edge and capture strobe in the wrong cycle. Configuration that leaks in while a transfer runs changes the spacing of the next launch. An error in the idle or stop path shows as a stray launch, or as a clock level other than the polarity, one cycle after the stop. Every cycle of the outputs is compared with a reference built from the requirements, so each of these faults is reported in the cycle it first appears.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sg_state_e;

endpackage

// File: rtl/sclk_ratio_dec.sv
module sclk_ratio_dec #(
    parameter int PRESC_W = 5,
    parameter int CNT_W   = 5
) (
    input  logic [PRESC_W-1:0] presc_i,
    output logic [CNT_W-1:0]   ratio_o,
    output logic [CNT_W-1:0]   half_o
);
    localparam int NIB_W = PRESC_W - 1;

    logic [CNT_W-1:0] nib_ext;
    logic [CNT_W-1:0] raw;

    always_comb begin
        nib_ext = CNT_W'(presc_i[NIB_W-1:0]);
        raw     = presc_i[PRESC_W-1] ? (nib_ext << 1) : nib_ext;
        ratio_o = (raw < CNT_W'(2)) ? CNT_W'(2) : raw;
        half_o  = (ratio_o >> 1) + CNT_W'(ratio_o[0]);
    end

endmodule

// File: rtl/sclk_level.sv
module sclk_level #(
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] pos_i,
    input  logic [CNT_W-1:0] half_i,
    input  logic             cpol_i,
    input  logic             cpha_i,
    output logic             level_o
);
    always_comb begin
        level_o = cpol_i ^ cpha_i ^ (pos_i >= half_i);
    end

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
    import sclk_gen_pkg::*;
#(
    parameter int PRESC_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en_i,
    input  logic               stop_req_i,
    input  logic [PRESC_W-1:0] presc_i,
    input  logic               cpol_i,
    input  logic               cpha_i,
    input  logic               capt_alt_i,
    output logic               sclk_o,
    output logic               launch_o,
    output logic               sample_o
);
    localparam int NIB_W     = PRESC_W - 1;
    localparam int MAX_RATIO = 2 * ((1 << NIB_W) - 1);
    localparam int CNT_W     = $clog2(MAX_RATIO + 1);

    typedef struct packed {
        sg_state_e        st;
        logic [CNT_W-1:0] pos;
        logic [CNT_W-1:0] ratio;
        logic [CNT_W-1:0] half;
        logic             cpol;
        logic             cpha;
        logic             capt;
        logic             sclk;
        logic             launch;
        logic             sample;
    } regs_t;

    localparam regs_t RST_VAL = '{
        st:     ST_IDLE,
        pos:    '0,
        ratio:  CNT_W'(2),
        half:   CNT_W'(1),
        cpol:   1'b0,
        cpha:   1'b0,
        capt:   1'b0,
        sclk:   1'b0,
        launch: 1'b0,
        sample: 1'b0
    };

    regs_t r_d, r_q;

    logic [CNT_W-1:0] dec_ratio;
    logic [CNT_W-1:0] dec_half;
    logic [CNT_W-1:0] pos_inc;
    logic             lvl_mid;
    logic             last_cyc;

    sclk_ratio_dec #(
        .PRESC_W(PRESC_W),
        .CNT_W  (CNT_W)
    ) u_dec (
        .presc_i(presc_i),
        .ratio_o(dec_ratio),
        .half_o (dec_half)
    );

    assign pos_inc  = r_q.pos + CNT_W'(1);
    assign last_cyc = (r_q.pos == (r_q.ratio - CNT_W'(1)));

    sclk_level #(
        .CNT_W(CNT_W)
    ) u_lvl (
        .pos_i  (pos_inc),
        .half_i (r_q.half),
        .cpol_i (r_q.cpol),
        .cpha_i (r_q.cpha),
        .level_o(lvl_mid)
    );

    always_comb begin
        r_d        = r_q;
        r_d.launch = 1'b0;
        r_d.sample = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                // configuration tracks the inputs while idle
                r_d.ratio = dec_ratio;
                r_d.half  = dec_half;
                r_d.cpol  = cpol_i;
                r_d.cpha  = cpha_i;
                r_d.capt  = capt_alt_i;
                r_d.sclk  = cpol_i;
                r_d.pos   = '0;
                if (run_en_i && !stop_req_i) begin
                    r_d.st     = ST_RUN;
                    r_d.launch = 1'b1;
                    r_d.sclk   = cpol_i ^ cpha_i;
                end
            end
            default: begin
                if (!run_en_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.sclk = r_q.cpol;
                    r_d.pos  = '0;
                end else if (last_cyc) begin
                    // bit boundary: alternate capture lands here
                    r_d.sample = r_q.capt;
                    r_d.pos    = '0;
                    if (stop_req_i) begin
                        r_d.st   = ST_IDLE;
                        r_d.sclk = r_q.cpol;
                    end else begin
                        r_d.launch = 1'b1;
                        r_d.sclk   = r_q.cpol ^ r_q.cpha;
                    end
                end else begin
                    r_d.pos    = pos_inc;
                    r_d.sclk   = lvl_mid;
                    r_d.sample = !r_q.capt && (pos_inc == r_q.half);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign sclk_o   = r_q.sclk;
    assign launch_o = r_q.launch;
    assign sample_o = r_q.sample;

    // R2: the latched ratio stays inside the legal range
    a_r2_ratio_range: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ratio >= CNT_W'(2)) && (r_q.ratio <= CNT_W'(MAX_RATIO)));

    // R3: launch only at the first cycle of a bit period
    a_r3_launch_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |-> (r_q.st == ST_RUN) && (r_q.pos == '0));

    // R5: normal capture sits at the half point
    a_r5_sample_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_o && !r_q.capt) |-> (r_q.pos == r_q.half));

    // R6: alternate capture sits on a bit boundary
    a_r6_alt_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_o && r_q.capt) |-> (r_q.pos == '0));

    // R4: serial clock moves only at bit start or half point
    a_r4_sclk_edges: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_RUN) && $past(r_q.st == ST_RUN) && !$stable(sclk_o))
        |-> ((r_q.pos == '0) || (r_q.pos == r_q.half)));

    // R11: configuration frozen while running
    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_RUN) && $past(r_q.st == ST_RUN))
        |-> ($stable(r_q.ratio) && $stable(r_q.cpol) && $stable(r_q.cpha) && $stable(r_q.capt)));

    // R10: enable low while running gives idle next cycle
    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_RUN) && !run_en_i) |=> ((r_q.st == ST_IDLE) && !launch_o && !sample_o));

endmodule

// File: tb/spi_sclk_gen_test.sv
module spi_sclk_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       stop_req = 1'b0;
    logic [4:0] presc = 5'd0;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       capt = 1'b0;
    logic       sclk;
    logic       launch;
    logic       sample;

    int n_chk = 0;
    int n_bad = 0;
    int l1, l2, s1;

    always #10 clk = ~clk;

    spi_sclk_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en_i  (en),
        .stop_req_i(stop_req),
        .presc_i   (presc),
        .cpol_i    (cpol),
        .cpha_i    (cpha),
        .capt_alt_i(capt),
        .sclk_o    (sclk),
        .launch_o  (launch),
        .sample_o  (sample)
    );

    function automatic int exp_ratio(logic [4:0] p);
        int r;
        r = p[4] ? 2 * int'(p[3:0]) : int'(p[3:0]);
        if (r < 2) r = 2;
        return r;
    endfunction

    // reference model written from the requirements
    bit m_busy, m_cpol, m_cpha, m_capt, m_sclk, m_launch, m_sample;
    int m_pos, m_n;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_pos = 0; m_n = 2; m_cpol = 0; m_cpha = 0; m_capt = 0;
            m_sclk = 0; m_launch = 0; m_sample = 0;
        end else if (!m_busy) begin
            m_cpol = cpol; m_cpha = cpha; m_capt = capt; m_n = exp_ratio(presc);
            m_launch = 0; m_sample = 0; m_sclk = cpol; m_pos = 0;
            if (en && !stop_req) begin
                m_busy = 1; m_launch = 1; m_sclk = cpol ^ cpha;
            end
        end else if (!en) begin
            m_busy = 0; m_sclk = m_cpol; m_launch = 0; m_sample = 0; m_pos = 0;
        end else if (m_pos == m_n - 1) begin
            m_sample = m_capt; m_pos = 0;
            if (stop_req) begin
                m_busy = 0; m_launch = 0; m_sclk = m_cpol;
            end else begin
                m_launch = 1; m_sclk = m_cpol ^ m_cpha;
            end
        end else begin
            m_pos = m_pos + 1; m_launch = 0;
            m_sample = !m_capt && (m_pos == (m_n + 1) / 2);
            m_sclk = m_cpol ^ m_cpha ^ (m_pos >= (m_n + 1) / 2);
        end
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check("R4 sclk vs model", int'(sclk), int'(m_sclk));
        check("R3 launch vs model", int'(launch), int'(m_launch));
        check("R5/R6 sample vs model", int'(sample), int'(m_sample));
    endtask

    task automatic observe(int ncyc);
        l1 = -1; l2 = -1; s1 = -1;
        for (int k = 0; k < ncyc; k++) begin
            tick();
            if (launch) begin
                if (l1 < 0) l1 = k;
                else if (l2 < 0) l2 = k;
            end
            if (sample && s1 < 0) s1 = k;
        end
    endtask

    task automatic stop_all();
        stop_req = 1'b1;
        for (int k = 0; k < 40 && m_busy; k++) tick();
        en = 1'b0;
        stop_req = 1'b0;
        tick();
    endtask

    task automatic measure(logic [4:0] p, int exp_n, int exp_h, string tag);
        presc = p; cpol = 0; cpha = 0; capt = 0; en = 1'b1;
        observe(2 * exp_n + 2);
        check({tag, " R8 start latency"}, l1, 0);
        check({tag, " R2/R3 period"}, l2 - l1, exp_n);
        check({tag, " R5 sample offset"}, s1 - l1, exp_h);
        stop_all();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cnt;
        void'($urandom(32'd4711));
        // R1: reset state
        tick();
        check("R1 sclk in reset", int'(sclk), 0);
        check("R1 launch in reset", int'(launch), 0);
        check("R1 sample in reset", int'(sample), 0);
        rst_n = 1'b1;
        tick();
        check("R1 sclk after reset", int'(sclk), 0);

        // R2 decoding and spacing
        measure(5'd3,  3,  2,  "R2 code3");
        measure(5'd15, 15, 8,  "R2 code15");
        measure(5'd23, 14, 7,  "R2 code23");
        measure(5'd31, 30, 15, "R2 code31");
        measure(5'd0,  2,  1,  "R2 code0");
        measure(5'd1,  2,  1,  "R2 code1");
        measure(5'd16, 2,  1,  "R2 code16");
        measure(5'd5,  5,  3,  "R2 code5");

        // R7: idle level follows polarity
        cpol = 1'b1; tick(); tick();
        check("R7 idle sclk high", int'(sclk), 1);
        check("R7 no launch idle", int'(launch), 0);
        cpha = 1'b1; tick();
        check("R7 idle ignores phase", int'(sclk), 1);

        // R4 mode 3, ratio 4
        presc = 5'd4; en = 1'b1;
        tick();
        check("R4 mode3 first half", int'(sclk), 0);
        check("R8 mode3 launch", int'(launch), 1);
        tick();
        check("R4 mode3 first half b", int'(sclk), 0);
        tick();
        check("R4 mode3 second half", int'(sclk), 1);
        check("R5 mode3 sample", int'(sample), 1);
        // R10 abort mid bit
        en = 1'b0; tick();
        check("R10 abort sclk", int'(sclk), 1);
        check("R10 abort launch", int'(launch), 0);
        check("R10 abort sample", int'(sample), 0);
        tick();
        check("R10 stays idle", int'(launch), 0);
        cpol = 0; cpha = 0; tick();

        // R6 alternate capture, ratio 2
        presc = 5'd2; capt = 1'b1; en = 1'b1;
        observe(6);
        check("R6 sample on next launch", s1 - l1, 2);
        stop_req = 1'b1; tick();
        check("R6 sample on return to idle", int'(sample), 1);
        check("R9 no launch at stop", int'(launch), 0);
        check("R9 sclk at polarity", int'(sclk), 0);
        en = 1'b0; stop_req = 1'b0; capt = 1'b0; tick();

        // R9 stop request mid bit, ratio 8
        presc = 5'd8; en = 1'b1;
        tick(); tick(); tick();
        stop_req = 1'b1;
        cnt = 0; s1 = 0;
        for (int k = 0; k < 10; k++) begin
            tick();
            if (launch) cnt++;
            if (sample) s1++;
        end
        check("R9 no launch after stop", cnt, 0);
        check("R9 bit completed", s1, 1);
        check("R9 idle level", int'(sclk), 0);
        en = 1'b0; stop_req = 1'b0; tick();

        // R11 config change ignored while running
        presc = 5'd6; en = 1'b1;
        tick();
        presc = 5'd3; cpha = 1'b1; capt = 1'b1;
        observe(13);
        check("R11 first launch", l1, 5);
        check("R11 period kept", l2 - l1, 6);
        stop_all();
        cpha = 0; capt = 0;

        // random mix, compared to the model each cycle
        for (int it = 0; it < 200; it++) begin
            presc = 5'($urandom);
            cpol = 1'($urandom); cpha = 1'($urandom); capt = 1'($urandom);
            en = 1'b1; stop_req = 1'b0;
            cnt = 5 + int'($urandom % 56);
            for (int c = 0; c < cnt; c++) begin
                tick();
                if ($urandom % 40 == 0) en = ~en;
                if ($urandom % 30 == 0) stop_req = ~stop_req;
                if ($urandom % 10 == 0) begin
                    presc = 5'($urandom);
                    cpol = 1'($urandom); cpha = 1'($urandom); capt = 1'($urandom);
                end
            end
            en = 1'b0; stop_req = 1'b0;
            tick(); tick();
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule